// File: doc/BRIEF.md
# SPI Master Transmit FIFO Sequencer

This block is the transmit half of a byte-wide SPI master that spans two clock domains. On the bus clock, a host pushes words into a dual-clock transmit FIFO. On a separate reference clock, a shift engine pops each word and sends it out on a single data lane in SPI mode 0. The serial clock runs at half the reference rate. The byte captured from the input lane during each word is returned on a plain output with a one-cycle valid strobe.

The bus side keeps its own occupancy counter. The counter rests at all ones when nothing is outstanding, so one pending word reads as zero. When the last word of a burst finishes shifting, the bus side raises a one-cycle transmit-empty interrupt. The interrupt needs three things at once: the counter is zero, the synchronised FIFO-empty flag is set, and the word-complete event has arrived.

Between words, the engine waits two reference cycles after each completion before it requests the next word. If the FIFO is empty when a word completes, the engine stalls. A refill then restarts it through a fresh start pulse. The delayed completion request is honoured only while the transfer-start level is still high. This means a refill that lands inside the stall window produces exactly one read, not two. A host can therefore extend a burst at any moment with extra dummy words.

Top module: `spitx_seq`

## Requirements
- R1: After reset, `cs_n` is 1, `sclk` is 0, `mosi` is 0, `occ_cnt` is all ones (0x3F), and `tx_empty_irq`, `rx_valid` and `wr_full` are 0.
- R2: `sclk` idles low. While a word shifts, each high phase lasts one `ref_clk` cycle and consecutive rising edges are two `ref_clk` cycles apart.
- R3: Bytes leave on `mosi` most significant bit first, in the order they were accepted, with none lost or repeated. `mosi` changes only while `sclk` is low.
- R4: `miso` is sampled on each `sclk` rising edge. At the end of each word, `rx_data` holds the eight samples (first sample in bit 7) and `rx_valid` pulses for one `ref_clk` cycle.
- R5: `occ_cnt` rises by one per accepted write and falls by one per completed word, so N words queued and not yet sent read as N-1 (modulo 64). It changes by at most one per bus cycle.
- R6: `tx_empty_irq` is a one-`bus_clk` pulse. It is raised only when a word completes while `occ_cnt` is 0 and the FIFO is empty. A burst written faster than it drains gives exactly one pulse.
- R7: A refill arriving at any time relative to a word's completion, including the post-word stall window, loses or duplicates no word, and `occ_cnt` returns to 0x3F.
- R8: While `inhibit` is 1, no transfer starts. After release, all words already queued leave in one frame.
- R9: `cs_n` goes low before the first `sclk` rise of a frame. It rises only when a word completes with the FIFO empty. `sclk` never rises while `cs_n` is high.
- R10: A write while `wr_full` is 1 is dropped and leaves `occ_cnt` unchanged. The FIFO holds 16 words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | Host-side clock |
| bus_rst | input | 1 | Synchronous active-high reset, bus domain |
| wr_valid | input | 1 | Write strobe for one word |
| wr_data | input | 8 | Word to transmit |
| inhibit | input | 1 | Holds off the start of a new frame while 1 |
| wr_full | output | 1 | FIFO full; writes are dropped |
| occ_cnt | output | 6 | Outstanding-word counter, all ones when idle |
| tx_empty_irq | output | 1 | One-cycle pulse when the last outstanding word completes |
| ref_clk | input | 1 | Serial reference clock |
| ref_rst | input | 1 | Synchronous active-high reset, reference domain |
| sclk | output | 1 | Serial clock, half of `ref_clk`, idles low |
| mosi | output | 1 | Serial data out |
| cs_n | output | 1 | Active-low chip select |
| miso | input | 1 | Serial data in |
| rx_data | output | 8 | Byte captured during the last word |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |

## Verification
A read-enable or start sequencer that drifts shows up at the serial lane within one word time, as a byte missing from or repeated in the expected stream. It also shows up on the bus side as an `occ_cnt` that never returns to all ones, and as an interrupt that stays silent. The hardest case is a refill timed against each possible completion instant. The write delay is therefore swept cycle by cycle across a full word, so that the two-cycle stall window is hit. A bad crossing of the completion event or the empty flag shows as a stuck counter or a missing pulse a few bus cycles after the last `sclk` edge.

// File: rtl/spitx_pkg.sv
package spitx_pkg;
  typedef enum logic [2:0] {
    ENG_IDLE,
    ENG_ARM,
    ENG_LOAD,
    ENG_SHIFT,
    ENG_POST
  } eng_state_t;
endpackage

// File: rtl/spitx_sync.sv
// Multi-stage synchroniser for a level or a Gray-coded vector.
module spitx_sync #(
  parameter int W       = 1,
  parameter int STAGES  = 2,
  parameter bit RST_ONE = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= {W{RST_ONE}};
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/spitx_afifo.sv
// Dual-clock FIFO with Gray pointers and registered read data (RAM-inferable).
module spitx_afifo #(
  parameter int DW          = 8,
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          wclk,
  input  logic          wrst,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic          wfull,
  input  logic          rclk,
  input  logic          rrst,
  input  logic          rd_en,
  output logic [DW-1:0] rdata,
  output logic          rempty
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW:0] wbin, wgray, wbin_nxt, wgray_nxt, rgray_w;
  logic [AW:0] rbin, rgray, rbin_nxt, rgray_nxt, wgray_r;
  logic wpush, rpop;

  // write side
  assign wpush     = wr_en & ~wfull;
  assign wbin_nxt  = wbin + {{AW{1'b0}}, wpush};
  assign wgray_nxt = (wbin_nxt >> 1) ^ wbin_nxt;

  always_ff @(posedge wclk) begin
    if (wrst) begin
      wbin  <= '0;
      wgray <= '0;
      wfull <= 1'b0;
    end else begin
      wbin  <= wbin_nxt;
      wgray <= wgray_nxt;
      wfull <= (wgray_nxt == {~rgray_w[AW:AW-1], rgray_w[AW-2:0]});
    end
  end

  always_ff @(posedge wclk) begin
    if (wpush) mem[wbin[AW-1:0]] <= wdata;
  end

  // read side
  assign rpop      = rd_en & ~rempty;
  assign rbin_nxt  = rbin + {{AW{1'b0}}, rpop};
  assign rgray_nxt = (rbin_nxt >> 1) ^ rbin_nxt;

  always_ff @(posedge rclk) begin
    if (rrst) begin
      rbin   <= '0;
      rgray  <= '0;
      rempty <= 1'b1;
    end else begin
      rbin   <= rbin_nxt;
      rgray  <= rgray_nxt;
      rempty <= (rgray_nxt == wgray_r);
    end
  end

  always_ff @(posedge rclk) begin
    if (rpop) rdata <= mem[rbin[AW-1:0]];
  end

  spitx_sync #(.W(AW+1), .STAGES(SYNC_STAGES), .RST_ONE(1'b0)) u_r2w (
    .clk(wclk), .rst(wrst), .d(rgray), .q(rgray_w)
  );
  spitx_sync #(.W(AW+1), .STAGES(SYNC_STAGES), .RST_ONE(1'b0)) u_w2r (
    .clk(rclk), .rst(rrst), .d(wgray), .q(wgray_r)
  );
endmodule

// File: rtl/spitx_occupancy.sv
// Bus-domain outstanding-word counter and transmit-empty interrupt.
module spitx_occupancy #(
  parameter int CW          = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          done_tgl_async,
  input  logic          empty_async,
  output logic [CW-1:0] occ,
  output logic          irq
);
  logic tgl_s, tgl_q, done_p, empty_s;

  spitx_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_ONE(1'b0)) u_done (
    .clk(clk), .rst(rst), .d(done_tgl_async), .q(tgl_s)
  );
  spitx_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_ONE(1'b1)) u_empty (
    .clk(clk), .rst(rst), .d(empty_async), .q(empty_s)
  );

  assign done_p = tgl_s ^ tgl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tgl_q <= 1'b0;
      occ   <= '1;
      irq   <= 1'b0;
    end else begin
      tgl_q <= tgl_s;
      irq   <= done_p & (occ == '0) & empty_s;
      case ({push, done_p})
        2'b10:   occ <= occ + CW'(1);
        2'b01:   occ <= occ - CW'(1);
        default: occ <= occ;
      endcase
    end
  end
endmodule

// File: rtl/spitx_engine.sv
// Reference-domain shift engine and guarded FIFO read sequencer.
module spitx_engine
  import spitx_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold_async,
  input  logic          fifo_empty,
  input  logic [DW-1:0] fifo_data,
  output logic          fifo_rd,
  input  logic          miso,
  output logic          sclk,
  output logic          mosi,
  output logic          cs_n,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid,
  output logic          done_tgl
);
  localparam int BW = (DW > 1) ? $clog2(DW) : 1;

  eng_state_t    state;
  logic          hold_s;
  logic          xfer_on, xfer_on_q, start_p;
  logic          done_p, done_d1, done_d2;
  logic [BW-1:0] bitcnt;
  logic [DW-1:0] txsh, rxsh;

  spitx_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_ONE(1'b1)) u_hold (
    .clk(clk), .rst(rst), .d(hold_async), .q(hold_s)
  );

  assign start_p = xfer_on & ~xfer_on_q;
  // A delayed completion only reads while the transfer level is still high;
  // after a stall the restart pulse alone issues the read.
  assign fifo_rd = ~fifo_empty & (start_p | (done_d2 & xfer_on));
  assign mosi    = txsh[DW-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ENG_IDLE;
      xfer_on   <= 1'b0;
      xfer_on_q <= 1'b0;
      done_p    <= 1'b0;
      done_d1   <= 1'b0;
      done_d2   <= 1'b0;
      done_tgl  <= 1'b0;
      bitcnt    <= '0;
      txsh      <= '0;
      rxsh      <= '0;
      sclk      <= 1'b0;
      cs_n      <= 1'b1;
      rx_data   <= '0;
      rx_valid  <= 1'b0;
    end else begin
      xfer_on_q <= xfer_on;
      done_d1   <= done_p;
      done_d2   <= done_d1;
      done_p    <= 1'b0;
      rx_valid  <= 1'b0;
      case (state)
        ENG_IDLE: begin
          if (!fifo_empty && !hold_s) begin
            xfer_on <= 1'b1;
            state   <= ENG_ARM;
          end
        end
        ENG_ARM: state <= ENG_LOAD;
        ENG_LOAD: begin
          txsh   <= fifo_data;
          cs_n   <= 1'b0;
          sclk   <= 1'b0;
          bitcnt <= '0;
          state  <= ENG_SHIFT;
        end
        ENG_SHIFT: begin
          if (!sclk) begin
            sclk <= 1'b1;
            rxsh <= {rxsh[DW-2:0], miso};
          end else begin
            sclk <= 1'b0;
            if (bitcnt == BW'(DW-1)) begin
              done_p   <= 1'b1;
              done_tgl <= ~done_tgl;
              rx_data  <= rxsh;
              rx_valid <= 1'b1;
              state    <= ENG_POST;
              if (fifo_empty) begin
                xfer_on <= 1'b0;
                cs_n    <= 1'b1;
              end
            end else begin
              bitcnt <= bitcnt + BW'(1);
              txsh   <= {txsh[DW-2:0], 1'b0};
            end
          end
        end
        ENG_POST: begin
          if (done_d2) state <= xfer_on ? ENG_LOAD : ENG_IDLE;
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spitx_seq.sv
// Top: transmit FIFO sequencer of a byte-wide SPI master.
module spitx_seq #(
  parameter int DW          = 8,
  parameter int DEPTH       = 16,
  parameter int CW          = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic          bus_clk,
  input  logic          bus_rst,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  input  logic          inhibit,
  output logic          wr_full,
  output logic [CW-1:0] occ_cnt,
  output logic          tx_empty_irq,
  input  logic          ref_clk,
  input  logic          ref_rst,
  output logic          sclk,
  output logic          mosi,
  output logic          cs_n,
  input  logic          miso,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid
);
  logic          fifo_rd, fifo_empty, done_tgl, push_ok;
  logic [DW-1:0] fifo_data;

  assign push_ok = wr_valid & ~wr_full;

  spitx_afifo #(.DW(DW), .DEPTH(DEPTH), .SYNC_STAGES(SYNC_STAGES)) u_fifo (
    .wclk(bus_clk), .wrst(bus_rst), .wr_en(wr_valid), .wdata(wr_data), .wfull(wr_full),
    .rclk(ref_clk), .rrst(ref_rst), .rd_en(fifo_rd), .rdata(fifo_data), .rempty(fifo_empty)
  );

  spitx_engine #(.DW(DW), .SYNC_STAGES(SYNC_STAGES)) u_eng (
    .clk(ref_clk), .rst(ref_rst), .hold_async(inhibit), .fifo_empty(fifo_empty),
    .fifo_data(fifo_data), .fifo_rd(fifo_rd), .miso(miso), .sclk(sclk), .mosi(mosi),
    .cs_n(cs_n), .rx_data(rx_data), .rx_valid(rx_valid), .done_tgl(done_tgl)
  );

  spitx_occupancy #(.CW(CW), .SYNC_STAGES(SYNC_STAGES)) u_occ (
    .clk(bus_clk), .rst(bus_rst), .push(push_ok), .done_tgl_async(done_tgl),
    .empty_async(fifo_empty), .occ(occ_cnt), .irq(tx_empty_irq)
  );
endmodule

// File: rtl/spitx_seq_chk.sv
module spitx_seq_chk #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int CW    = 6
) (
  input logic          bus_clk,
  input logic          bus_rst,
  input logic [CW-1:0] occ_cnt,
  input logic          tx_empty_irq,
  input logic          ref_clk,
  input logic          ref_rst,
  input logic          sclk,
  input logic          mosi,
  input logic          cs_n,
  input logic          rx_valid,
  input logic [DW-1:0] rx_data
);
  // R2
  sclk_high_one_cycle_chk: assert property (@(posedge ref_clk) disable iff (ref_rst)
    sclk |=> !sclk);
  // R9
  no_sclk_without_cs_chk: assert property (@(posedge ref_clk) disable iff (ref_rst)
    cs_n |-> !sclk);
  // R3
  mosi_steady_high_chk: assert property (@(posedge ref_clk) disable iff (ref_rst)
    sclk |-> $stable(mosi));
  // R4
  rx_strobe_single_chk: assert property (@(posedge ref_clk) disable iff (ref_rst)
    rx_valid |=> !rx_valid);
  // R4
  rx_data_hold_chk: assert property (@(posedge ref_clk) disable iff (ref_rst)
    !rx_valid |-> $stable(rx_data));
  // R5
  occ_unit_step_chk: assert property (@(posedge bus_clk) disable iff (bus_rst)
    (occ_cnt - $past(occ_cnt) == CW'(1)) || ($past(occ_cnt) - occ_cnt == CW'(1)) ||
    (occ_cnt == $past(occ_cnt)));
  // R10
  occ_range_chk: assert property (@(posedge bus_clk) disable iff (bus_rst)
    (occ_cnt == {CW{1'b1}}) || (occ_cnt < CW'(DEPTH + 2)));
  // R6
  irq_from_last_word_chk: assert property (@(posedge bus_clk) disable iff (bus_rst)
    tx_empty_irq |-> ($past(occ_cnt) == '0));
  // R6
  irq_single_pulse_chk: assert property (@(posedge bus_clk) disable iff (bus_rst)
    tx_empty_irq |=> !tx_empty_irq);
endmodule

bind spitx_seq spitx_seq_chk #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_chk (
  .bus_clk(bus_clk), .bus_rst(bus_rst), .occ_cnt(occ_cnt), .tx_empty_irq(tx_empty_irq),
  .ref_clk(ref_clk), .ref_rst(ref_rst), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
  .rx_valid(rx_valid), .rx_data(rx_data)
);

// File: tb/spitx_seq_test.sv
module spitx_seq_test;
  localparam int DEPTH = 16;

  logic       bus_clk = 1'b0, ref_clk = 1'b0;
  logic       bus_rst = 1'b1, ref_rst = 1'b1;
  logic       wr_valid = 1'b0, inhibit = 1'b0;
  logic [7:0] wr_data = '0;
  logic       wr_full, tx_empty_irq, sclk, mosi, cs_n, miso, rx_valid;
  logic [5:0] occ_cnt;
  logic [7:0] rx_data;

  always #4  bus_clk = ~bus_clk;
  always #20 ref_clk = ~ref_clk;

  assign miso = ~mosi;  // inverted loopback: received byte is the complement

  spitx_seq uut (
    .bus_clk(bus_clk), .bus_rst(bus_rst), .wr_valid(wr_valid), .wr_data(wr_data),
    .inhibit(inhibit), .wr_full(wr_full), .occ_cnt(occ_cnt), .tx_empty_irq(tx_empty_irq),
    .ref_clk(ref_clk), .ref_rst(ref_rst), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
    .miso(miso), .rx_data(rx_data), .rx_valid(rx_valid)
  );

  int checks = 0, errors = 0;
  int irq_cnt = 0, frame_cnt = 0;
  logic [7:0] exp_q [$];
  logic [7:0] rx_q [$];

  function automatic void chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endfunction

  // serial-side monitor, sampled on the falling edge of ref_clk
  logic       sclk_prev = 1'b0, cs_prev = 1'b1;
  int         since_rise = 0, nbits = 0;
  logic [7:0] cap = '0;
  always @(negedge ref_clk) begin
    if (!ref_rst) begin
      since_rise++;
      if (sclk && !sclk_prev) begin
        chk(!cs_n, "R9", "sclk rise with cs_n high", cs_n, 0);
        if (nbits != 0) chk(since_rise == 2, "R2", "sclk rise spacing", since_rise, 2);
        since_rise = 0;
        cap = {cap[6:0], mosi};
        nbits++;
        if (nbits == 8) begin
          nbits = 0;
          if (exp_q.size() == 0) chk(0, "R3", "unexpected byte", cap, 0);
          else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            chk(cap == e, "R3", "serial byte", cap, e);
          end
          rx_q.push_back(~cap);
        end
      end
      if (rx_valid) begin
        if (rx_q.size() == 0) chk(0, "R4", "unexpected rx strobe", rx_data, 0);
        else begin
          logic [7:0] r;
          r = rx_q.pop_front();
          chk(rx_data == r, "R4", "received byte", rx_data, r);
        end
      end
      if (cs_n && !cs_prev) frame_cnt++;
      sclk_prev = sclk;
      cs_prev   = cs_n;
    end
  end

  always @(negedge bus_clk) if (!bus_rst && tx_empty_irq) irq_cnt++;

  task automatic push_word(input logic [7:0] d, output bit took);
    @(negedge bus_clk);
    took     = !wr_full;
    wr_valid = 1'b1;
    wr_data  = d;
    if (took) exp_q.push_back(d);
    @(negedge bus_clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while (!(exp_q.size() == 0 && rx_q.size() == 0 && cs_n && occ_cnt == 6'h3F) && n < 6000) begin
      @(negedge bus_clk);
      n++;
    end
    if (n >= 6000) chk(0, req, "drain timeout, bytes pending", exp_q.size(), 0);
    repeat (12) @(negedge bus_clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (180000) @(posedge bus_clk);
    chk(0, "watchdog", "run did not complete", 0, 1);
    finish_run();
  end

  initial begin
    bit took;
    int accepted;
    void'($urandom(32'h00C0FFEE));
    repeat (8) @(posedge ref_clk);
    @(negedge bus_clk);
    bus_rst = 1'b0;
    ref_rst = 1'b0;
    repeat (4) @(negedge bus_clk);
    // R1 reset state
    chk(cs_n == 1'b1, "R1", "cs_n", cs_n, 1);
    chk(sclk == 1'b0, "R1", "sclk", sclk, 0);
    chk(mosi == 1'b0, "R1", "mosi", mosi, 0);
    chk(occ_cnt == 6'h3F, "R1", "occ_cnt", occ_cnt, 6'h3F);
    chk(tx_empty_irq == 1'b0, "R1", "irq", tx_empty_irq, 0);
    chk(wr_full == 1'b0, "R1", "wr_full", wr_full, 0);
    chk(rx_valid == 1'b0, "R1", "rx_valid", rx_valid, 0);

    // R5 / R8: queue under inhibit, then release
    inhibit = 1'b1;
    repeat (10) @(negedge bus_clk);
    push_word(8'hA5, took); push_word(8'h3C, took); push_word(8'h81, took);
    push_word(8'h00, took); push_word(8'hFF, took);
    repeat (40) @(negedge bus_clk);
    chk(occ_cnt == 6'd4, "R5", "occ after 5 writes", occ_cnt, 4);
    chk(exp_q.size() == 5, "R8", "bytes held by inhibit", exp_q.size(), 5);
    chk(cs_n == 1'b1, "R8", "cs_n under inhibit", cs_n, 1);
    irq_cnt = 0; frame_cnt = 0;
    inhibit = 1'b0;
    wait_idle("R8");
    chk(frame_cnt == 1, "R8", "frames after release", frame_cnt, 1);
    chk(irq_cnt == 1, "R6", "irq pulses for one burst", irq_cnt, 1);
    chk(occ_cnt == 6'h3F, "R5", "occ after drain", occ_cnt, 6'h3F);

    // R10: overfill under inhibit
    inhibit = 1'b1;
    repeat (10) @(negedge bus_clk);
    accepted = 0;
    for (int i = 0; i < DEPTH + 3; i++) begin
      push_word(8'(8'h10 + i), took);
      if (took) accepted++;
    end
    repeat (4) @(negedge bus_clk);
    chk(wr_full == 1'b1, "R10", "wr_full", wr_full, 1);
    chk(accepted == DEPTH, "R10", "accepted writes", accepted, DEPTH);
    chk(occ_cnt == 6'(DEPTH - 1), "R10", "occ at full", occ_cnt, DEPTH - 1);
    irq_cnt = 0; frame_cnt = 0;
    inhibit = 1'b0;
    wait_idle("R10");
    chk(frame_cnt == 1, "R9", "one frame for full burst", frame_cnt, 1);
    chk(irq_cnt == 1, "R6", "irq after full burst", irq_cnt, 1);

    // R6: single word
    irq_cnt = 0;
    push_word(8'h5A, took);
    wait_idle("R6");
    chk(irq_cnt == 1, "R6", "irq for single word", irq_cnt, 1);

    // R7: sweep refill timing across a whole word and its stall window
    for (int k = 30; k < 170; k++) begin
      irq_cnt = 0;
      push_word(8'(k), took);
      repeat (k) @(negedge bus_clk);
      push_word(8'(~k), took);
      wait_idle("R7");
      chk(irq_cnt >= 1 && irq_cnt <= 2, "R7", "irq count for refill", irq_cnt, 1);
      chk(occ_cnt == 6'h3F, "R7", "occ after refill", occ_cnt, 6'h3F);
    end

    // random bursts with random gaps
    for (int b = 0; b < 40; b++) begin
      int n;
      n = 1 + int'($urandom % 6);
      irq_cnt = 0;
      for (int w = 0; w < n; w++) begin
        push_word(8'($urandom), took);
        repeat ($urandom % 60) @(negedge bus_clk);
      end
      wait_idle("R3");
      chk(irq_cnt >= 1, "R6", "irq after random burst", irq_cnt, 1);
      chk(occ_cnt == 6'h3F, "R5", "occ after random burst", occ_cnt, 6'h3F);
    end

    finish_run();
  end
endmodule